// File: doc/BRIEF.md
# Peripheral Bus Access Sequencer with Acknowledge Timeout

This block sits between a host-side request port and a 16-bit peripheral bus whose acknowledge is active low. A request carries up to 64 bits of data, an address, eight byte enables and a read/write flag. The block splits each request into up to four 16-bit peripheral transfers and runs them lowest word first. The four words form two 32-bit halves, and each half behaves like a standalone 32-bit access. Every transfer is given a bounded number of clocks to be acknowledged. An input selects a short limit or a long limit.

A transfer that is not acknowledged in time is a bus error. For a read, the rest of its 32-bit half is abandoned, and the completion word for each abandoned or failed word becomes 0xFFFF. A word with no enabled bytes is never put on the bus and always completes as 0x0000. A failed write is dropped and the request still completes. Every request ends with a one-cycle completion strobe and a matching credit-return pulse. A sticky error flag, cleared by a one-cycle pulse, drives an interrupt output through an enable. Software can use this behaviour to probe empty slots: a read that comes back as all-ones means no peripheral answered.

Top module: `pbus_xfer_seq`

## Requirements
- R1: A request is accepted on a clock where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. Word k (k = 0..3) of a request is issued in ascending order of k. It is issued with `pb_be = req_be[2k+1:2k]`, `pb_wdata = req_wdata[16k+15:16k]`, `pb_we = req_write` and `pb_addr = {req_addr[AW-1:3], k[1:0], 1'b0}`.
- R2: A word whose two byte enables are both 0 is never driven on the bus (`pb_sel` stays low for it). Its 16-bit field in `cpl_data` is 0x0000, with or without a bus error.
- R3: `pb_sel` stays high for one transfer until `pb_ack_n` is sampled low, or for at most L clocks. L is 16 when the `tmo_long_sel` value latched at acceptance is 0, and 64 when it is 1. An acknowledge in the L-th clock still succeeds. The count restarts for every transfer.
- R4: When the lower word of a 32-bit half (word 0 or 2) times out, the upper word of that half is not issued. Both words of that half read back as 0xFFFF if any of their own byte enables is set, and as 0x0000 otherwise.
- R5: When the upper word of a half times out after the lower word was acknowledged, the upper field is 0xFFFF and the lower field carries the acknowledged read data.
- R6: The two 32-bit halves of a 64-bit request are independent. A timeout in one half does not change what is issued or returned in the other half.
- R7: Acknowledged read words return `pb_rdata` as sampled with the acknowledge. A write completes with `cpl_data` equal to 0, and this also holds when one of its transfers timed out.
- R8: Every accepted request produces exactly one clock of `cpl_valid` with `credit_rtn` high in the same clock. `cpl_err` is 1 exactly when at least one of its transfers timed out.
- R9: After a completion, including one with a bus error, `req_ready` is high in the next clock.
- R10: `err_flag` is set by any transfer timeout and stays set until an `err_clr` pulse. When a timeout and a clear happen together, the set wins. `irq` equals `err_flag` AND `irq_en`.
- R11: After reset, `req_ready` is 1, and `pb_sel`, `cpl_valid`, `credit_rtn`, `err_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address (bits 2:0 ignored) |
| req_be | input | 8 | Byte enables, bit n covers byte n |
| req_wdata | input | 64 | Write data |
| tmo_long_sel | input | 1 | Timeout select: 0 = short, 1 = long limit |
| pb_sel | output | 1 | Peripheral transfer in progress |
| pb_we | output | 1 | Peripheral write |
| pb_addr | output | AW | Peripheral word address |
| pb_be | output | 2 | Peripheral byte enables |
| pb_wdata | output | 16 | Peripheral write data |
| pb_rdata | input | 16 | Peripheral read data |
| pb_ack_n | input | 1 | Active-low acknowledge |
| cpl_valid | output | 1 | Completion strobe, one clock |
| cpl_err | output | 1 | Completion had a bus error |
| cpl_data | output | 64 | Completion read data |
| credit_rtn | output | 1 | Credit-return pulse |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | Clear pulse for the error flag |
| err_flag | output | 1 | Sticky bus-error flag |
| irq | output | 1 | Interrupt output |

## Verification
The hardest cases to reach are the boundaries of the acknowledge window. One is an acknowledge arriving in the very last allowed clock. Another is one arriving a clock too late. A third is a timeout on the upper word of a half whose lower word was acknowledged. The bench's peripheral model takes a separate acknowledge delay for each word, and that delay can be "never". Directed requests set the delay to exactly L-1 and L under both timeout settings, and place the failing word in each position of each half. Random requests then mix sparse byte enables with frequent never-acknowledged words.

// File: rtl/pbus_xfer_seq.sv
module pbus_xfer_seq #(
  parameter int AW        = 16,
  parameter int TMO_SHORT = 16,
  parameter int TMO_LONG  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_be,
  input  logic [63:0]   req_wdata,
  input  logic          tmo_long_sel,
  output logic          pb_sel,
  output logic          pb_we,
  output logic [AW-1:0] pb_addr,
  output logic [1:0]    pb_be,
  output logic [15:0]   pb_wdata,
  input  logic [15:0]   pb_rdata,
  input  logic          pb_ack_n,
  output logic          cpl_valid,
  output logic          cpl_err,
  output logic [63:0]   cpl_data,
  output logic          credit_rtn,
  input  logic          irq_en,
  input  logic          err_clr,
  output logic          err_flag,
  output logic          irq
);

  localparam int CW = $clog2(TMO_LONG + 1);
  localparam logic [CW-1:0] LIM_S = CW'(TMO_SHORT - 1);
  localparam logic [CW-1:0] LIM_L = CW'(TMO_LONG - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_BUS, S_DONE} state_t;

  state_t          state;
  logic [1:0]      idx;
  logic [7:0]      be_q;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [63:0]     wd_q;
  logic [63:0]     rd_q;
  logic [1:0]      abort_q;
  logic            err_q;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim_q;

  logic [1:0] cur_be;
  logic [1:0] mate_be;
  logic       tmo_hit;
  logic       ack_hit;
  logic       last_w;

  assign cur_be  = be_q[{idx, 1'b0} +: 2];
  assign mate_be = be_q[{idx[1], 2'b10} +: 2];
  assign tmo_hit = (state == S_BUS) && pb_ack_n && (cnt == lim_q);
  assign ack_hit = (state == S_BUS) && !pb_ack_n;
  assign last_w  = (idx == 2'd3);

  assign req_ready  = (state == S_IDLE);
  assign pb_sel     = (state == S_BUS);
  assign pb_we      = wr_q;
  assign pb_be      = cur_be;
  assign pb_addr    = {addr_q[AW-1:3], idx, 1'b0};
  assign pb_wdata   = wd_q[{idx, 4'b0} +: 16];
  assign cpl_valid  = (state == S_DONE);
  assign credit_rtn = (state == S_DONE);
  assign cpl_err    = err_q;
  assign cpl_data   = rd_q;
  assign irq        = err_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      abort_q <= '0;
      err_q   <= 1'b0;
      cnt     <= '0;
      lim_q   <= LIM_S;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          be_q    <= req_be;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          lim_q   <= tmo_long_sel ? LIM_L : LIM_S;
          rd_q    <= '0;
          abort_q <= '0;
          err_q   <= 1'b0;
          idx     <= '0;
          state   <= S_EVAL;
        end
        S_EVAL: begin
          if ((cur_be != 2'b00) && !abort_q[idx[1]]) begin
            cnt   <= '0;
            state <= S_BUS;
          end else if (last_w) begin
            state <= S_DONE;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_BUS: begin
          if (ack_hit || tmo_hit) begin
            if (ack_hit && !wr_q)
              rd_q[{idx, 4'b0} +: 16] <= pb_rdata;
            if (tmo_hit) begin
              err_q <= 1'b1;
              if (!wr_q)
                rd_q[{idx, 4'b0} +: 16] <= 16'hFFFF;
              if (!idx[0]) begin
                abort_q[idx[1]] <= 1'b1;
                if (!wr_q && (mate_be != 2'b00))
                  rd_q[{idx[1], 5'b10000} +: 16] <= 16'hFFFF;
              end
            end
            if (last_w) state <= S_DONE;
            else begin
              idx   <= idx + 2'd1;
              state <= S_EVAL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (tmo_hit)  err_flag <= 1'b1;
    else if (err_clr)  err_flag <= 1'b0;
  end

endmodule

// File: rtl/pbus_xfer_seq_chk.sv
module pbus_xfer_seq_chk #(
  parameter int TMO_LONG = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       pb_sel,
  input logic [1:0] pb_be,
  input logic       cpl_valid,
  input logic       err_flag,
  input logic       err_clr
);
  localparam int RW = $clog2(TMO_LONG + 2);
  logic [RW-1:0] sel_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_run <= '0;
    else if (pb_sel)  sel_run <= sel_run + 1'b1;
    else              sel_run <= '0;
  end

  assert_no_sel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !pb_sel);
  assert_no_empty_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pb_sel |-> (pb_be != 2'b00));
  assert_sel_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_run <= RW'(TMO_LONG));
  assert_cpl_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);
  assert_ready_after_cpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> req_ready);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind pbus_xfer_seq pbus_xfer_seq_chk #(.TMO_LONG(TMO_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .pb_sel(pb_sel),
  .pb_be(pb_be), .cpl_valid(cpl_valid), .err_flag(err_flag), .err_clr(err_clr)
);

// File: tb/pbus_xfer_seq_test.sv
module pbus_xfer_seq_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, tmo_long_sel = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_be = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, pb_sel, pb_we, cpl_valid, cpl_err, credit_rtn, err_flag, irq;
  logic [AW-1:0] pb_addr;
  logic [1:0] pb_be;
  logic [15:0] pb_wdata, pb_rdata;
  logic pb_ack_n = 1'b1;
  logic irq_en = 1'b0, err_clr = 1'b0;
  logic [63:0] cpl_data;

  int checks = 0, fails = 0;
  int dly [4];
  int sel_len [4];
  logic [3:0] issued;
  logic [7:0] tag = 8'h00;
  int bad_fields;
  logic model_flag = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  assign pb_rdata = {tag ^ 8'hA5, 6'd0, pb_addr[2:1]};

  pbus_xfer_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .tmo_long_sel(tmo_long_sel), .pb_sel(pb_sel), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_be(pb_be), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .pb_ack_n(pb_ack_n),
    .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_data(cpl_data), .credit_rtn(credit_rtn),
    .irq_en(irq_en), .err_clr(err_clr), .err_flag(err_flag), .irq(irq)
  );

  // peripheral model: ack after dly[w] clocks of pb_sel, also records what was issued
  always @(negedge clk) begin
    if (pb_sel) begin
      automatic int w = int'(pb_addr[2:1]);
      issued[w] = 1'b1;
      if (pb_be != req_be[2*w +: 2] || pb_we != req_write ||
          pb_wdata != req_wdata[16*w +: 16] || pb_addr[AW-1:3] != req_addr[AW-1:3])
        bad_fields++;
      pb_ack_n = (sel_len[w] == dly[w]) ? 1'b0 : 1'b1;
      sel_len[w]++;
    end else begin
      pb_ack_n = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  task automatic run(input bit wr, input logic [7:0] be, input bit tsel,
                     input int d0, input int d1, input int d2, input int d3);
    int lim, cyc;
    logic [63:0] exp_d;
    logic [3:0] exp_iss;
    bit exp_err, abort;
    logic [63:0] got_d;
    bit got_err, got_cr;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    for (int i = 0; i < 4; i++) sel_len[i] = 0;
    issued = '0; bad_fields = 0;
    lim = tsel ? 64 : 16;
    @(negedge clk);
    tag = 8'($urandom);
    req_write = wr; req_be = be; tmo_long_sel = tsel;
    req_addr = AW'($urandom); req_wdata = {$urandom, $urandom};
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    tmo_long_sel = ~tsel;
    cyc = 0;
    while (!cpl_valid && cyc < 1000) begin @(negedge clk); cyc++; end
    got_d = cpl_data; got_err = cpl_err; got_cr = credit_rtn;
    // expected values from the requirements
    exp_d = '0; exp_iss = '0; exp_err = 1'b0;
    for (int h = 0; h < 2; h++) begin
      abort = 1'b0;
      for (int k = 0; k < 2; k++) begin
        automatic int w = 2*h + k;
        if (be[2*w +: 2] == 2'b00) continue;
        if (abort) begin
          if (!wr) exp_d[16*w +: 16] = 16'hFFFF;
          continue;
        end
        exp_iss[w] = 1'b1;
        if (dly[w] >= lim) begin
          exp_err = 1'b1;
          if (!wr) exp_d[16*w +: 16] = 16'hFFFF;
          if (k == 0) abort = 1'b1;
        end else if (!wr) begin
          exp_d[16*w +: 16] = {tag ^ 8'hA5, 6'd0, 2'(w)};
        end
      end
    end
    if (exp_err) model_flag = 1'b1;
    chk(cyc < 1000, "R8 completion arrives", 64'(cyc), 64'd0);
    chk(got_d == exp_d, wr ? "R7 write completion data" : "R4 R5 R6 R7 R2 read completion data", got_d, exp_d);
    chk(got_err == exp_err, "R8 cpl_err", 64'(got_err), 64'(exp_err));
    chk(got_cr == 1'b1, "R8 credit with completion", 64'(got_cr), 64'd1);
    chk(issued == exp_iss, "R1 R2 R4 issued words", 64'(issued), 64'(exp_iss));
    chk(bad_fields == 0, "R1 transfer fields", 64'(bad_fields), 64'd0);
    for (int w = 0; w < 4; w++) if (exp_iss[w]) begin
      automatic int el = (dly[w] >= lim) ? lim : dly[w] + 1;
      chk(sel_len[w] == el, "R3 select length", 64'(sel_len[w]), 64'(el));
    end
    chk(err_flag == model_flag, "R10 sticky flag", 64'(err_flag), 64'(model_flag));
    chk(irq == (model_flag & irq_en), "R10 irq gating", 64'(irq), 64'(model_flag & irq_en));
    @(negedge clk);
    chk(req_ready == 1'b1 && cpl_valid == 1'b0 && credit_rtn == 1'b0, "R9 R8 idle after completion",
        {61'd0, req_ready, cpl_valid, credit_rtn}, 64'd4);
  endtask

  task automatic clear_flag();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    model_flag = 1'b0;
    chk(err_flag == 1'b0, "R10 clear", 64'(err_flag), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) begin dly[i] = 0; sel_len[i] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && pb_sel == 1'b0 && cpl_valid == 1'b0 && credit_rtn == 1'b0 &&
        err_flag == 1'b0 && irq == 1'b0, "R11 reset state",
        {58'd0, req_ready, pb_sel, cpl_valid, credit_rtn, err_flag, irq}, 64'h20);
    rst_n = 1'b1;
    irq_en = 1'b1;
    // directed corner cases
    run(1'b0, 8'h0F, 1'b0, NEVER, 0, 0, 0);         // R4 first word of 32-bit read fails
    run(1'b0, 8'h0F, 1'b0, 2, NEVER, 0, 0);         // R5 second word fails
    run(1'b0, 8'hFF, 1'b0, NEVER, 1, 3, 0);         // R6 lower half fails, upper fine
    run(1'b0, 8'hFF, 1'b0, 0, 1, 5, NEVER);         // R6 R5 upper half second word fails
    clear_flag();
    run(1'b0, 8'h0F, 1'b0, 15, 15, 0, 0);           // R3 ack in last allowed clock
    chk(err_flag == 1'b0, "R3 ack at limit is no error", 64'(err_flag), 64'd0);
    run(1'b0, 8'h03, 1'b0, 16, 0, 0, 0);            // R3 one clock too late
    run(1'b0, 8'h0F, 1'b1, 63, 40, 0, 0);           // R3 long limit
    run(1'b0, 8'h0F, 1'b1, 2, 64, 0, 0);            // R3 long limit exceeded
    run(1'b0, 8'h0C, 1'b0, 0, NEVER, 0, 0);         // R2 R5 lower word disabled
    run(1'b0, 8'h3C, 1'b0, NEVER, 0, 0, 0);         // R2 empty word0, word1 issued
    run(1'b0, 8'h00, 1'b0, 0, 0, 0, 0);             // R2 no enabled bytes at all
    run(1'b0, 8'h21, 1'b0, NEVER, 0, 0, 0);         // R4 partial enables
    run(1'b1, 8'hFF, 1'b0, 0, NEVER, 1, 2);         // R7 write timeout
    irq_en = 1'b0;
    run(1'b1, 8'hF3, 1'b0, NEVER, 0, 0, 0);         // R7 R10 irq masked
    clear_flag();
    // simultaneous set and clear: set wins
    @(negedge clk);
    dly[0] = NEVER; dly[1] = 0; dly[2] = 0; dly[3] = 0;
    for (int i = 0; i < 4; i++) sel_len[i] = 0;
    req_write = 1'b0; req_be = 8'h03; tmo_long_sel = 1'b0; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!(pb_sel && sel_len[0] == 15)) @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err_flag == 1'b1, "R10 set beats clear", 64'(err_flag), 64'd1);
    while (!cpl_valid) @(negedge clk);
    @(negedge clk);
    model_flag = 1'b1;
    clear_flag();
    irq_en = 1'b1;
    // random traffic
    for (int n = 0; n < 160; n++) begin
      automatic int d [4];
      automatic logic [7:0] be;
      automatic int pick = $urandom % 4;
      be = (pick == 0) ? 8'hFF : (pick == 1) ? 8'h0F : 8'($urandom);
      for (int i = 0; i < 4; i++) begin
        automatic int r = $urandom % 10;
        d[i] = (r < 2) ? NEVER : (r == 2) ? 15 : (r == 3) ? 16 : int'($urandom % 6);
      end
      run(1'($urandom), be, ($urandom % 4) == 0, d[0], d[1], d[2], d[3]);
      if ((n % 7) == 0) clear_flag();
    end
    finish_run();
  end
endmodule